// File: doc/BRIEF.md
# Zero-Skipping Activation Stream Encoder

This block sits at the output of a neural-network layer, before the activations are written back for the next layer. Each accepted beat carries one group of signed fixed-point activations, one per lane. Every lane turns its own column of activations into a narrow, compacted stream. Only effectual values pass. Each one carries the index of the beat it came from within its brick, so that a later multiply stage can fetch the matching weight and skip every product with a removed value.

A value counts as ineffectual when its magnitude is at or below a programmable threshold. With the threshold at zero only exact zeros are removed and the result is lossless. A larger threshold also drops near-zero values, which trades some accuracy for fewer products. The decision is made at run time on every value: no position is assumed to be zero in advance. A brick is a run of up to sixteen beats. It closes when the producer marks its last beat, or on its own after the sixteenth beat. At the close every lane emits a marker that carries the number of values it kept in that brick. A lane that kept nothing still emits one marker with a count of zero.

Each lane has its own valid/ready output. A single stalled lane holds back the whole input group, so no value is ever dropped.

Top module: `zs_encoder`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, every `out_valid` bit is 0 and `in_ready` is 1.
- R2: A lane value is kept exactly when its absolute value (the most negative code taken as 2^(DW-1)) is strictly greater than `cfg_thresh`, read as unsigned. With `cfg_thresh` = 0 every non-zero value is kept.
- R3: A removed value never reaches the output. An entry with `out_has` = 0 shows an `out_value` of 0.
- R4: `out_offset` (4 bits per lane, lane l at bits [4l+3:4l]) is the beat index of the value within its brick, starting at 0. Within a lane, the entries of a brick come out in increasing offset order.
- R5: On the beat that closes a brick, every lane emits an entry with `out_last` = 1. In every entry, `out_count` (5 bits per lane) is the number of kept values in that lane's brick up to and including that entry.
- R6: A lane that keeps no value in a brick emits exactly one entry for it: `out_has` = 0, `out_last` = 1, `out_count` = 0, at the offset of the closing beat.
- R7: While any lane has `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0. That lane's entry holds stable, and no accepted value is lost.
- R8: A brick closes on an accepted beat that has `in_last` = 1, or on the sixteenth accepted beat (offset 15) even without `in_last`. The next beat then starts at offset 0.
- R9: A lane emits an entry only for a kept value or for a brick close. The value of lane l is at bits [16l+15:16l] of `in_data` and `out_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_thresh | input | 16 | Unsigned magnitude threshold, sampled with each accepted beat |
| in_valid | input | 1 | Input group valid |
| in_ready | output | 1 | Input group accepted when high together with in_valid |
| in_data | input | 256 | Sixteen signed 16-bit activations, lane l at [16l+15:16l] |
| in_last | input | 1 | Marks the final beat of a brick |
| out_valid | output | 16 | Per-lane entry valid |
| out_ready | input | 16 | Per-lane consumer ready |
| out_has | output | 16 | Per-lane: entry carries a kept value |
| out_value | output | 256 | Per-lane kept value, zero when none |
| out_offset | output | 64 | Per-lane beat index within the brick |
| out_last | output | 16 | Per-lane brick-close marker |
| out_count | output | 80 | Per-lane running count of kept values in the brick |

## Verification
On every cycle, the assertions check that a stalled lane holds its entry and blocks the input side. They also check that no entry carries a removed or zero value, that every entry is either a value or a close marker, and that a count never exceeds the offset plus one. The exact keep decision against the threshold, the offset order, the count on each close, the single marker of an empty brick and the forced close after sixteen beats can only be shown by the bench scenarios. There, a queue-based model predicts every lane's stream and compares it with the output, including under random per-lane back-pressure.

// File: rtl/zs_pkg.sv
// Package: shared sizing defaults for the zero-skipping encoder.
// Assumes: modules take these as parameter defaults and derive their own widths.
package zs_pkg;
    localparam int ZS_LANES = 16;
    localparam int ZS_DW    = 16;
    localparam int ZS_BRICK = 16;

    // Width of a field that must hold the values 0..n-1.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a field that must hold the values 0..n.
    function automatic int cnt_w(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/zs_sieve.sv
// Module: zs_sieve
// Decides whether one signed activation is effectual: its magnitude must
// exceed the unsigned threshold. Purely combinational.
// Assumes: two's complement input; the most negative code has magnitude 2^(DW-1).
module zs_sieve #(
    parameter int DW = zs_pkg::ZS_DW
) (
    input  logic [DW-1:0] value,
    input  logic [DW-1:0] thresh,
    output logic          keep
);
    logic [DW-1:0] mag;

    // Absolute value; negating the most negative code wraps to 2^(DW-1) unsigned.
    always_comb begin
        mag  = value[DW-1] ? (~value + DW'(1)) : value;
        keep = (mag > thresh);
    end
endmodule

// File: rtl/zs_brick_pos.sv
// Module: zs_brick_pos
// Tracks the beat index inside the current brick, shared by all lanes.
// Flags the closing beat: in_last or the final slot of a full brick.
// Assumes: advance is high only on an accepted beat.
module zs_brick_pos #(
    parameter int BRICK = zs_pkg::ZS_BRICK,
    parameter int OFFW  = zs_pkg::idx_w(BRICK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    input  logic            in_last,
    output logic [OFFW-1:0] pos,
    output logic            close
);
    localparam logic [OFFW-1:0] LAST_POS = OFFW'(BRICK - 1);

    // Closing beat: explicit marker or brick full.
    always_comb close = in_last || (pos == LAST_POS);

    // Advance the index, wrapping to zero after a close.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (advance)
            pos <= close ? '0 : pos + OFFW'(1);
    end
endmodule

// File: rtl/zs_lane.sv
// Module: zs_lane
// One compacted output stream: registers an entry for a kept value or a
// brick close, and keeps the running count of kept values in the brick.
// Assumes: load is asserted only when this lane's register is empty or is
// being drained in the same cycle (the top gates the input on that).
module zs_lane #(
    parameter int DW   = zs_pkg::ZS_DW,
    parameter int OFFW = 4,
    parameter int CNTW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            keep,
    input  logic [DW-1:0]   value,
    input  logic [OFFW-1:0] pos,
    input  logic            close,
    input  logic            o_ready,
    output logic            o_valid,
    output logic            o_has,
    output logic [DW-1:0]   o_value,
    output logic [OFFW-1:0] o_offset,
    output logic            o_last,
    output logic [CNTW-1:0] o_count
);
    logic [CNTW-1:0] run_q;
    logic [CNTW-1:0] run_next;
    logic            emit;

    // An entry is produced for a kept value or for the brick close.
    always_comb begin
        emit     = keep || close;
        run_next = run_q + CNTW'(keep);
    end

    // Output entry register with valid/ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid  <= 1'b0;
            o_has    <= 1'b0;
            o_value  <= '0;
            o_offset <= '0;
            o_last   <= 1'b0;
            o_count  <= '0;
        end else if (load) begin
            o_valid <= emit;
            if (emit) begin
                o_has    <= keep;
                o_value  <= keep ? value : '0;
                o_offset <= pos;
                o_last   <= close;
                o_count  <= run_next;
            end
        end else if (o_ready) begin
            o_valid <= 1'b0;
        end
    end

    // Running count of kept values, cleared after each close.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (load)
            run_q <= close ? '0 : run_next;
    end
endmodule

// File: rtl/zs_encoder.sv
// Module: zs_encoder (top)
// Zero-skipping activation encoder: one group of LANES activations per beat
// in, one compacted value/offset stream per lane out. Values with magnitude
// at or below cfg_thresh are removed; each brick ends with a per-lane close
// marker carrying the count of kept values.
// Assumes: bricks are at most BRICK beats; cfg_thresh is read per beat.
module zs_encoder #(
    parameter int LANES = zs_pkg::ZS_LANES,
    parameter int DW    = zs_pkg::ZS_DW,
    parameter int BRICK = zs_pkg::ZS_BRICK,
    parameter int OFFW  = zs_pkg::idx_w(BRICK),
    parameter int CNTW  = zs_pkg::cnt_w(BRICK)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DW-1:0]         cfg_thresh,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [LANES*DW-1:0]   in_data,
    input  logic                  in_last,
    output logic [LANES-1:0]      out_valid,
    input  logic [LANES-1:0]      out_ready,
    output logic [LANES-1:0]      out_has,
    output logic [LANES*DW-1:0]   out_value,
    output logic [LANES*OFFW-1:0] out_offset,
    output logic [LANES-1:0]      out_last,
    output logic [LANES*CNTW-1:0] out_count
);
    logic            fire;
    logic            close;
    logic [OFFW-1:0] pos;
    logic [LANES-1:0] keep;

    // The group is taken only when no lane holds an undrained entry.
    always_comb begin
        in_ready = ~|(out_valid & ~out_ready);
        fire     = in_valid && in_ready;
    end

    zs_brick_pos #(.BRICK(BRICK), .OFFW(OFFW)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (fire),
        .in_last (in_last),
        .pos     (pos),
        .close   (close)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        zs_sieve #(.DW(DW)) u_sieve (
            .value  (in_data[l*DW +: DW]),
            .thresh (cfg_thresh),
            .keep   (keep[l])
        );

        zs_lane #(.DW(DW), .OFFW(OFFW), .CNTW(CNTW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (fire),
            .keep     (keep[l]),
            .value    (in_data[l*DW +: DW]),
            .pos      (pos),
            .close    (close),
            .o_ready  (out_ready[l]),
            .o_valid  (out_valid[l]),
            .o_has    (out_has[l]),
            .o_value  (out_value[l*DW +: DW]),
            .o_offset (out_offset[l*OFFW +: OFFW]),
            .o_last   (out_last[l]),
            .o_count  (out_count[l*CNTW +: CNTW])
        );
    end
endmodule

// File: rtl/zs_encoder_chk.sv
// Module: zs_encoder_chk
// Property checker for zs_encoder, attached by bind. Observes ports only.
module zs_encoder_chk #(
    parameter int LANES = 16,
    parameter int DW    = 16,
    parameter int OFFW  = 4,
    parameter int CNTW  = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_ready,
    input logic [LANES-1:0]      out_valid,
    input logic [LANES-1:0]      out_ready,
    input logic [LANES-1:0]      out_has,
    input logic [LANES*DW-1:0]   out_value,
    input logic [LANES*OFFW-1:0] out_offset,
    input logic [LANES-1:0]      out_last,
    input logic [LANES*CNTW-1:0] out_count
);
    // R1: the cycle after a reset edge shows no valid entry.
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0));

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        // R7: a held entry stays put until taken.
        a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[l] && !out_ready[l]) |=>
                (out_valid[l] && $stable(out_has[l]) && $stable(out_last[l])
                 && $stable(out_value[l*DW +: DW])
                 && $stable(out_offset[l*OFFW +: OFFW])
                 && $stable(out_count[l*CNTW +: CNTW])));

        // R7: a stalled lane blocks the input group.
        a_r7_block_input: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[l] && !out_ready[l]) |-> !in_ready);

        // R3: no removed value is exposed.
        a_r3_removed_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[l] && !out_has[l]) |-> (out_value[l*DW +: DW] == '0));

        // R2: a kept value is never zero.
        a_r2_kept_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[l] && out_has[l]) |-> (out_value[l*DW +: DW] != '0));

        // R9: every entry is a value or a close marker.
        a_r9_entry_meaning: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[l] |-> (out_has[l] || out_last[l]));

        // R5: the count cannot exceed the beats seen so far in the brick.
        a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[l] |->
                (int'(out_count[l*CNTW +: CNTW]) <= int'(out_offset[l*OFFW +: OFFW]) + 1));

        // R5: an entry with a value counts at least that value.
        a_r5_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[l] && out_has[l]) |-> (out_count[l*CNTW +: CNTW] != '0));
    end
endmodule

bind zs_encoder zs_encoder_chk #(
    .LANES (LANES),
    .DW    (DW),
    .OFFW  (OFFW),
    .CNTW  (CNTW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_has    (out_has),
    .out_value  (out_value),
    .out_offset (out_offset),
    .out_last   (out_last),
    .out_count  (out_count)
);

// File: tb/zs_encoder_tb.sv
`timescale 1ns/1ps
module zs_encoder_tb;
    localparam int LANES = 16;
    localparam int DW    = 16;
    localparam int BRICK = 16;
    localparam int OFFW  = 4;
    localparam int CNTW  = 5;
    localparam int EW    = 2 + OFFW + CNTW + DW;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [DW-1:0]         cfg_thresh = '0;
    logic                  in_valid = 1'b0;
    logic                  in_ready;
    logic [LANES*DW-1:0]   in_data = '0;
    logic                  in_last = 1'b0;
    logic [LANES-1:0]      out_valid;
    logic [LANES-1:0]      out_ready = '1;
    logic [LANES-1:0]      out_has;
    logic [LANES*DW-1:0]   out_value;
    logic [LANES*OFFW-1:0] out_offset;
    logic [LANES-1:0]      out_last;
    logic [LANES*CNTW-1:0] out_count;

    int nvec = 0;
    int nfail = 0;
    bit rnd_ready = 1'b0;
    bit done = 1'b0;

    logic [EW-1:0] exp_q [LANES][$];
    int m_pos = 0;
    int m_cnt [LANES];

    always #2.5 clk = ~clk;

    zs_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
        .out_has(out_has), .out_value(out_value), .out_offset(out_offset),
        .out_last(out_last), .out_count(out_count)
    );

    function automatic logic [EW-1:0] pack(bit h, bit la, int off, int cnt, logic [DW-1:0] v);
        return {h, la, OFFW'(off), CNTW'(cnt), v};
    endfunction

    // Back-pressure driver.
    always @(negedge clk) begin
        if (rnd_ready) out_ready <= LANES'($urandom) | LANES'($urandom);
        else           out_ready <= '1;
    end

    // Reference model and per-cycle comparison.
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            bit exp_rdy;
            bit close;
            exp_rdy = 1'b1;
            for (int l = 0; l < LANES; l++)
                if (out_valid[l] && !out_ready[l]) exp_rdy = 1'b0;
            nvec++;
            if (in_ready !== exp_rdy) begin
                nfail++;
                $display("FAIL R7 in_ready got %0b expected %0b", in_ready, exp_rdy);
            end
            for (int l = 0; l < LANES; l++) begin
                if (out_valid[l]) begin
                    logic [EW-1:0] got;
                    logic [EW-1:0] exp;
                    got = pack(out_has[l], out_last[l], int'(out_offset[l*OFFW +: OFFW]),
                               int'(out_count[l*CNTW +: CNTW]), out_value[l*DW +: DW]);
                    nvec++;
                    if (!out_has[l] && out_value[l*DW +: DW] != '0) begin
                        nfail++;
                        $display("FAIL R3 lane %0d removed value shown %h expected 0",
                                 l, out_value[l*DW +: DW]);
                    end
                    if (exp_q[l].size() == 0) begin
                        nfail++;
                        $display("FAIL R9 lane %0d unexpected entry got %h expected none", l, got);
                    end else begin
                        exp = exp_q[l][0];
                        if (got !== exp) begin
                            string tag;
                            if (exp[EW-1] == 1'b0 && exp[EW-2] && exp[DW +: CNTW] == '0) tag = "R6";
                            else if (got[EW-1] !== exp[EW-1] || got[DW-1:0] !== exp[DW-1:0]) tag = "R2";
                            else if (got[DW+CNTW +: OFFW] !== exp[DW+CNTW +: OFFW]) tag = "R4";
                            else if (exp[EW-2] && exp[DW+CNTW +: OFFW] == OFFW'(BRICK-1)) tag = "R8";
                            else tag = "R5";
                            nfail++;
                            $display("FAIL %s lane %0d entry got %h expected %h", tag, l, got, exp);
                        end
                        if (out_ready[l]) void'(exp_q[l].pop_front());
                    end
                end
            end
            if (in_valid && in_ready) begin
                close = in_last || (m_pos == BRICK - 1);
                for (int l = 0; l < LANES; l++) begin
                    int d;
                    int mag;
                    bit k;
                    d   = int'($signed(in_data[l*DW +: DW]));
                    mag = (d < 0) ? -d : d;
                    k   = (mag > int'(cfg_thresh));
                    if (k || close)
                        exp_q[l].push_back(pack(k, close, m_pos, m_cnt[l] + int'(k),
                                                k ? in_data[l*DW +: DW] : '0));
                    m_cnt[l] = close ? 0 : m_cnt[l] + int'(k);
                end
                m_pos = close ? 0 : m_pos + 1;
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        summary();
        $finish;
    end

    task automatic put_beat(input logic [LANES*DW-1:0] d, input bit last);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    function automatic logic [LANES*DW-1:0] fill(input int v);
        logic [LANES*DW-1:0] r;
        for (int l = 0; l < LANES; l++) r[l*DW +: DW] = DW'(v);
        return r;
    endfunction

    function automatic logic [LANES*DW-1:0] rnd_group();
        logic [LANES*DW-1:0] r;
        for (int l = 0; l < LANES; l++) begin
            case ($urandom % 4)
                0, 3:    r[l*DW +: DW] = '0;
                1:       r[l*DW +: DW] = DW'(int'($urandom % 15) - 7);
                default: r[l*DW +: DW] = DW'($urandom);
            endcase
        end
        return r;
    endfunction

    initial begin
        logic [LANES*DW-1:0] g;
        for (int l = 0; l < LANES; l++) m_cnt[l] = 0;
        repeat (3) @(negedge clk);
        // R1: state during reset.
        nvec++;
        if (out_valid !== '0 || in_ready !== 1'b1) begin
            nfail++;
            $display("FAIL R1 during reset got valid %h ready %0b expected 0 and 1", out_valid, in_ready);
        end
        rst_n = 1'b1;
        @(negedge clk);
        nvec++;
        if (out_valid !== '0 || in_ready !== 1'b1) begin
            nfail++;
            $display("FAIL R1 after reset got valid %h ready %0b expected 0 and 1", out_valid, in_ready);
        end

        // R2, R4, R5: lossless brick of four beats with mixed lanes.
        cfg_thresh = '0;
        for (int b = 0; b < 4; b++) begin
            g = '0;
            for (int l = 0; l < LANES; l++)
                if (((l + b) % 3) != 0) g[l*DW +: DW] = DW'(l * 100 - b * 700 + 1);
            put_beat(g, b == 3);
        end

        // R6: brick of three all-zero beats.
        for (int b = 0; b < 3; b++) put_beat('0, b == 2);

        // R2: threshold boundary, magnitudes 4, 5, 6 and the most negative code.
        cfg_thresh = DW'(5);
        put_beat(fill(5), 1'b0);
        put_beat(fill(-5), 1'b0);
        put_beat(fill(6), 1'b0);
        put_beat(fill(-6), 1'b0);
        put_beat(fill(4), 1'b0);
        put_beat(fill(-32768), 1'b1);

        // R8: sixteen beats without a marker close on their own.
        cfg_thresh = '0;
        for (int b = 0; b < BRICK; b++) put_beat(fill(b % 2 == 0 ? 0 : b), 1'b0);
        put_beat(fill(9), 1'b0);
        put_beat(fill(0), 1'b1);

        // R7, R9: random data under random back-pressure.
        rnd_ready = 1'b1;
        for (int b = 0; b < 400; b++) begin
            if (b % 20 == 0) cfg_thresh = DW'($urandom % 8);
            put_beat(rnd_group(), ($urandom % 6) == 0);
        end

        rnd_ready = 1'b0;
        repeat (10) @(negedge clk);
        // R7: every accepted value must have come out.
        for (int l = 0; l < LANES; l++) begin
            nvec++;
            if (exp_q[l].size() != 0) begin
                nfail++;
                $display("FAIL R7 lane %0d entries left got %0d expected 0", l, exp_q[l].size());
            end
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule